// File: doc/BRIEF.md
# Byte-Serial 16x16 Multiply-Accumulate Engine

This block computes one FIR filter output as the sum of N unsigned products of a 16-bit coefficient and a 16-bit sample. It has a single 8x8 multiplier. Each product is split into four byte-by-byte partial products, which take four clock cycles. Each partial product is shifted into its weight and added into a 40-bit accumulator. The accumulator is wide enough that full-scale operands over 150 taps never wrap it. The operand bytes come from a byte-wide, read-only register file that has one cycle of registered read latency. The engine drives the address and takes one byte per cycle.

For tap k the four bytes sit at base address 4k. The offsets are: coefficient low at +0, coefficient high at +1, sample low at +2 and sample high at +3. The engine reads them in a fixed order: coefficient low, sample low, sample high, coefficient high. The last partial product of a tap (coefficient high times sample high) is computed from stored bytes while the next tap's coefficient low is being read, so the byte stream has no gaps. After the last tap, one drain cycle finishes the last product. The engine then pulses done and holds the sum until the next start.

Top module: `byte_mac`

## Requirements
- R1: For tap k, in the four consecutive cycles of its fetch, rd_addr_o is 4k+0, 4k+2, 4k+3, 4k+1. These are coefficient low, sample low, sample high and coefficient high.
- R2: The first address, 0, appears in the cycle after the clock edge that accepts start_i. Fetches then follow one per cycle with no gaps across all N taps.
- R3: result_o equals the sum over the N taps of coefficient times sample. The operands are unsigned 16-bit values assembled little-endian from the bytes above, and the sum is taken modulo 2^40.
- R4: An accepted start clears the accumulator, so no part of an earlier result carries into a new one.
- R5: For N greater than 0, done_o is high for exactly one cycle. That cycle is the 4N+2-th cycle after the accepting edge, counting the cycle right after that edge as 0.
- R6: After done_o, result_o holds its value until the next accepted start.
- R7: A tap count of 0 gives done_o in the cycle right after the accepting edge, with result_o equal to 0.
- R8: A start_i raised while a computation is running is ignored: the address sequence, the done timing and the result are unchanged.
- R9: After reset, done_o is 0 and result_o is 0.
- R10: 150 taps of full-scale operands (0xFFFF times 0xFFFF) accumulate exactly, without wrap-around.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin one output computation when idle |
| taps_i | input | TAP_W (8) | Number of taps, sampled with start_i |
| rd_addr_o | output | TAP_W+2 (10) | Byte read address to the register file |
| rd_data_i | input | 8 | Registered read data, one cycle after the address |
| result_o | output | 40 | Accumulated sum of products |
| done_o | output | 1 | One-cycle pulse when result_o is final |

## Verification
The hardest case to reach is the seam between taps. There, the fourth partial product of one tap is accumulated from stored bytes in the same cycle that the next tap's low coefficient byte arrives. It only matters when the stored high bytes differ from the new data. The bench fills the register file with distinct, pseudo-random byte patterns across several taps so that any swap of operands at the seam changes the sum. It also runs a full-scale 150-tap case that loads the top accumulator bits. A start pulse is injected halfway through a run to confirm that it has no effect.

// File: rtl/byte_mac_pkg.sv
package byte_mac_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DRAIN} seq_st_e;

  // fetch phases: 0 coef lo, 1 sample lo, 2 sample hi, 3 coef hi
  localparam logic [1:0] PH_CLO = 2'd0;
  localparam logic [1:0] PH_SLO = 2'd1;
  localparam logic [1:0] PH_SHI = 2'd2;
  localparam logic [1:0] PH_CHI = 2'd3;

  // byte offset inside a 4-byte tap record for a given phase
  function automatic logic [1:0] byte_off(input logic [1:0] ph);
    case (ph)
      PH_CLO:  byte_off = 2'd0;
      PH_SLO:  byte_off = 2'd2;
      PH_SHI:  byte_off = 2'd3;
      default: byte_off = 2'd1;
    endcase
  endfunction
endpackage

// File: rtl/mac_mul.sv
module mac_mul #(
  parameter int BYTE_W = 8
) (
  input  logic [BYTE_W-1:0]   a_i,
  input  logic [BYTE_W-1:0]   b_i,
  output logic [2*BYTE_W-1:0] p_o
);
  assign p_o = (2*BYTE_W)'(a_i) * (2*BYTE_W)'(b_i);
endmodule

// File: rtl/mac_seq.sv
module mac_seq
  import byte_mac_pkg::*;
#(
  parameter int TAP_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [TAP_W-1:0] taps_i,
  output logic [TAP_W+1:0] rd_addr_o,
  output logic             clr_o,
  output logic             use_vld_o,
  output logic [1:0]       use_ph_o,
  output logic             done_o
);
  seq_st_e          state_q;
  logic [TAP_W-1:0] tap_q, n_q;
  logic [1:0]       ph_q;
  logic             use_vld_q, done_q;
  logic [1:0]       use_ph_q;

  assign clr_o     = (state_q == ST_IDLE) && start_i;
  assign rd_addr_o = {tap_q, byte_off(ph_q)};
  assign use_vld_o = use_vld_q;
  assign use_ph_o  = use_ph_q;
  assign done_o    = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      tap_q     <= '0;
      n_q       <= '0;
      ph_q      <= '0;
      use_vld_q <= 1'b0;
      use_ph_q  <= '0;
      done_q    <= 1'b0;
    end else begin
      done_q    <= 1'b0;
      use_vld_q <= (state_q == ST_RUN);
      use_ph_q  <= ph_q;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            tap_q <= '0;
            ph_q  <= '0;
            n_q   <= taps_i;
            if (taps_i == '0) done_q  <= 1'b1;
            else              state_q <= ST_RUN;
          end
        end
        ST_RUN: begin
          ph_q <= ph_q + 2'd1;
          if (ph_q == PH_CHI) begin
            if (tap_q == n_q - 1'b1) state_q <= ST_DRAIN;
            else                     tap_q   <= tap_q + 1'b1;
          end
        end
        default: begin
          // wait for the last byte to be consumed, then one drain product
          if (!use_vld_q) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
      endcase
    end
  end

  // R5
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  // R2
  ph_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (use_vld_q && $past(use_vld_q)) |-> (use_ph_q == $past(use_ph_q) + 2'd1));
  // R8
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE && start_i) |=> $stable(n_q));
endmodule

// File: rtl/mac_dp.sv
module mac_dp
  import byte_mac_pkg::*;
#(
  parameter int ACC_W  = 40,
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              use_vld_i,
  input  logic [1:0]        use_ph_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic [ACC_W-1:0]  acc_o
);
  localparam int PW = 2 * BYTE_W;

  logic [BYTE_W-1:0] cl_q, sl_q, sh_q, ch_q;
  logic              pend_q;
  logic [ACC_W-1:0]  acc_q;
  logic [BYTE_W-1:0] op_a, op_b;
  logic [PW-1:0]     prod;
  logic [1:0]        wsel; // 0: x1, 1: x2^8, 2: x2^16
  logic              add_en, drain;

  assign drain = pend_q && (!use_vld_i || use_ph_i == PH_CLO);

  always_comb begin
    op_a   = ch_q;
    op_b   = sh_q;
    wsel   = 2'd2;
    add_en = drain;
    if (use_vld_i) begin
      case (use_ph_i)
        PH_SLO: begin op_a = cl_q;      op_b = rd_data_i; wsel = 2'd0; add_en = 1'b1; end
        PH_SHI: begin op_a = cl_q;      op_b = rd_data_i; wsel = 2'd1; add_en = 1'b1; end
        PH_CHI: begin op_a = rd_data_i; op_b = sl_q;      wsel = 2'd1; add_en = 1'b1; end
        default: ;
      endcase
    end
  end

  mac_mul #(.BYTE_W(BYTE_W)) u_mul (.a_i(op_a), .b_i(op_b), .p_o(prod));

  logic [ACC_W-1:0] addend;
  always_comb begin
    case (wsel)
      2'd0:    addend = ACC_W'(prod);
      2'd1:    addend = ACC_W'(prod) << BYTE_W;
      default: addend = ACC_W'(prod) << (2 * BYTE_W);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      pend_q <= 1'b0;
      cl_q   <= '0;
      sl_q   <= '0;
      sh_q   <= '0;
      ch_q   <= '0;
    end else if (clr_i) begin
      acc_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (add_en) acc_q <= acc_q + addend;
      if (drain)  pend_q <= 1'b0;
      if (use_vld_i) begin
        case (use_ph_i)
          PH_CLO: cl_q <= rd_data_i;
          PH_SLO: sl_q <= rd_data_i;
          PH_SHI: sh_q <= rd_data_i;
          default: begin
            ch_q   <= rd_data_i;
            pend_q <= 1'b1;
          end
        endcase
      end
    end
  end

  assign acc_o = acc_q;

  // R6
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !use_vld_i && !pend_q) |=> $stable(acc_q));
  // R1
  seam_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && use_vld_i) |-> (use_ph_i == PH_CLO));
endmodule

// File: rtl/byte_mac.sv
module byte_mac #(
  parameter int TAP_W = 8,
  parameter int ACC_W = 40
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [TAP_W-1:0] taps_i,
  output logic [TAP_W+1:0] rd_addr_o,
  input  logic [7:0]       rd_data_i,
  output logic [ACC_W-1:0] result_o,
  output logic             done_o
);
  logic       clr, use_vld;
  logic [1:0] use_ph;

  mac_seq #(.TAP_W(TAP_W)) u_seq (
    .clk_i, .rst_ni, .start_i, .taps_i,
    .rd_addr_o,
    .clr_o(clr), .use_vld_o(use_vld), .use_ph_o(use_ph),
    .done_o
  );

  mac_dp #(.ACC_W(ACC_W), .BYTE_W(8)) u_dp (
    .clk_i, .rst_ni,
    .clr_i(clr), .use_vld_i(use_vld), .use_ph_i(use_ph),
    .rd_data_i,
    .acc_o(result_o)
  );
endmodule

// File: tb/tb_byte_mac.sv
module tb_byte_mac;
  localparam int TAP_W = 8;
  localparam int AW    = TAP_W + 2;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [TAP_W-1:0] taps = '0;
  logic [AW-1:0]    rd_addr;
  logic [7:0]       rd_data = '0;
  logic [39:0]      result;
  logic             done;

  logic [7:0] mem [1 << AW];

  int checks = 0, errors = 0, cyc = 0;
  logic [31:0] lcg = 32'h1357_9bdf;

  byte_mac dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .taps_i(taps),
    .rd_addr_o(rd_addr), .rd_data_i(rd_data), .result_o(result), .done_o(done)
  );

  always #5 clk = ~clk;
  always @(posedge clk) rd_data <= mem[rd_addr];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual hung, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rnd();
    lcg = lcg * 32'd1664525 + 32'd1013904223;
    return lcg;
  endfunction

  task automatic put_tap(input int k, input logic [15:0] c, input logic [15:0] s);
    mem[4*k]   = c[7:0];
    mem[4*k+1] = c[15:8];
    mem[4*k+2] = s[7:0];
    mem[4*k+3] = s[15:8];
  endtask

  function automatic logic [39:0] model(input int n);
    longint unsigned sum = 0;
    for (int k = 0; k < n; k++)
      sum += longint'({mem[4*k+1], mem[4*k]}) * longint'({mem[4*k+3], mem[4*k+2]});
    return sum[39:0];
  endfunction

  function automatic int exp_addr(input int j);
    int off [4] = '{0, 2, 3, 1};
    return 4 * (j / 4) + off[j % 4];
  endfunction

  // runs one output; inject_at >= 0 pulses a stray start in that cycle
  task automatic run(input int n, input int inject_at, input string tag);
    logic [39:0] exp = model(n);
    @(negedge clk);
    start = 1'b1;
    taps  = TAP_W'(n);
    @(negedge clk);
    start = 1'b0;
    taps  = '0;
    if (n == 0) begin
      chk({tag, " R7 done"}, done, 1);
      chk({tag, " R7 result"}, result, 0);
      @(negedge clk);
      chk({tag, " R5 done width"}, done, 0);
      return;
    end
    for (int j = 0; j <= 4*n + 2; j++) begin
      if (j < 4*n) begin
        // R1 R2 address stream
        checks++;
        if (int'(rd_addr) != exp_addr(j)) begin
          errors++;
          $display("FAIL %s R1 addr j=%0d: actual %0d expected %0d", tag, j, rd_addr, exp_addr(j));
        end
      end
      // R5 done timing every cycle
      checks++;
      if (done !== (j == 4*n + 2)) begin
        errors++;
        $display("FAIL %s R5 done j=%0d: actual %0b expected %0b", tag, j, done, j == 4*n + 2);
      end
      if (j == 4*n + 2) chk({tag, " R3 result"}, result, exp);
      if (j == inject_at) begin start = 1'b1; taps = 8'd1; end
      else                begin start = 1'b0; taps = '0;   end
      @(negedge clk);
    end
    start = 1'b0;
    for (int h = 0; h < 4; h++) begin
      chk({tag, " R6 hold"}, result, exp);
      chk({tag, " R5 single"}, done, 0);
      @(negedge clk);
    end
  endtask

  initial begin
    for (int i = 0; i < (1 << AW); i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk("R9 done", done, 0);
    chk("R9 result", result, 0);
    rst_n = 1'b1;
    @(negedge clk);

    put_tap(0, 16'h1234, 16'hABCD);
    run(1, -1, "single");

    for (int k = 0; k < 6; k++) put_tap(k, rnd()[15:0], rnd()[23:8]);
    run(6, -1, "rand6");

    // R8: stray start in the middle of a run
    run(6, 9, "R8 busy");

    // R4: small result after a large one must not carry
    for (int k = 0; k < 150; k++) put_tap(k, 16'hFFFF, 16'hFFFF);
    run(150, -1, "R10 full");
    put_tap(0, 16'h0003, 16'h0005);
    run(1, -1, "R4 clear");

    // R7 zero taps after a nonzero result
    run(0, -1, "zero");

    // seam patterns: high bytes distinct from low bytes
    for (int k = 0; k < 9; k++) put_tap(k, {8'hF0 ^ 8'(k), 8'h01 + 8'(k)}, {8'h0F + 8'(k), 8'h80 ^ 8'(k*3)});
    run(9, -1, "R1 seam");

    // back-to-back start right after done
    run(2, -1, "b2b");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule